// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front-End

This block is the clocked control path of a pipelined burst static RAM. It has an 18-bit address space and a data bus of two 9-bit lanes. Each lane carries eight data bits and one parity bit. All control inputs are sampled on the rising clock edge, except the output enable, which acts at once.

An access opens with one of two active-low address strobes: a processor strobe and a controller strobe. Three chip selects decide whether that strobe selects or deselects the device. Once selected, the device walks a four-word block with a 2-bit counter, driven by an advance input. Writes come from either a global write input or a per-lane write path. Read data leaves through an output register and drives the bidirectional bus.

The storage is a small parameterised register array indexed by the low address bits, so that the whole path can be simulated.

Top module: `burst_sram_front`

## Requirements
- R1: A strobe selects the device only when sel_a_n=0, sel_b=1 and sel_c_n=0 at the same edge. A strobe with any select inactive does not open an access.
- R2: The processor strobe has no effect while sel_a_n is high, so a burst in progress continues. With sel_a_n low, the processor strobe opens a read at the presented address.
- R3: When both strobes are low at one edge, the processor strobe governs. That edge is a read, even with global write asserted and data on the bus.
- R4: An accepted strobe loads address bits [1:0] into the burst counter. The access at that edge uses the presented address.
- R5: With no strobe and advance_n low, the counter steps linearly and wraps inside the aligned four-word block (2, 3, 0, 1). With advance_n high, the counter and the block both hold.
- R6: all_wr_n low at an edge writes both lanes from data_io, whatever the values of lane_wr_en_n and lane_sel_n.
- R7: With lane_wr_en_n low, lane_sel_n[0]=0 writes data_io[8:0] and lane_sel_n[1]=0 writes data_io[17:9]. Unselected lanes keep their contents. With both write inputs high, the access is a read.
- R8: Read data for an access edge is on data_io just after that edge and stays until the next edge. After a write edge the bus is released.
- R9: out_en_n high releases data_io at once, without waiting for a clock. Taking it low again restores the registered read data.
- R10: The first read after the device was deselected keeps the bus released for that cycle. A read opened while the device is already selected drives at once.
- R11: A strobe with the selects inactive deselects the device. From the next edge the bus is released, and advance or write inputs neither read nor write until a new access opens.
- R12: After reset the device is deselected and data_io is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 18 | Access address |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| advance_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Per-lane write path enable, active low |
| lane_sel_n | input | 2 | Per-lane write selects, active low, bit i for lane i |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| data_io | inout | 18 | Bidirectional data bus, lane 1 in [17:9], lane 0 in [8:0] |

## Verification
Each access edge has two effects: a write lands in the array at that edge, and read data, or the released bus, shows just after it. The bench therefore presents inputs one nanosecond after an edge and reads the bus one nanosecond after the next edge. That edge is the one whose access it checks. The output enable is tested with no clock: the bench toggles it in the middle of a cycle and samples after a short delay. Writes are checked one edge later, by reopening the block for a read.

// File: rtl/bsf_pkg.sv
`timescale 1ns/1ps
package bsf_pkg;
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;
endpackage

// File: rtl/bsf_strobe_decode.sv
`timescale 1ns/1ps
module bsf_strobe_decode (
    input  logic strobe_cpu_n,
    input  logic strobe_ctl_n,
    input  logic sel_a_n,
    input  logic sel_b,
    input  logic sel_c_n,
    output logic start_o,
    output logic desel_o,
    output logic from_cpu_o
);
    logic cpu_ok;
    logic hit;
    logic selected;

    always_comb begin
        // processor strobe only counts while select A is active
        cpu_ok     = !strobe_cpu_n && !sel_a_n;
        hit        = cpu_ok || !strobe_ctl_n;
        selected   = !sel_a_n && sel_b && !sel_c_n;
        start_o    = hit && selected;
        desel_o    = hit && !selected;
        from_cpu_o = cpu_ok;
    end
endmodule

// File: rtl/bsf_write_decode.sv
`timescale 1ns/1ps
module bsf_write_decode #(
    parameter int LANES = 2
) (
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic             wr_req_o,
    output logic [LANES-1:0] lane_mask_o
);
    assign wr_req_o = !all_wr_n || !lane_wr_en_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask_o[g] = !all_wr_n || (!lane_wr_en_n && !lane_sel_n[g]);
    end
endmodule

// File: rtl/bsf_burst_ctrl.sv
`timescale 1ns/1ps
module bsf_burst_ctrl
    import bsf_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          desel_i,
    input  logic          from_cpu_i,
    input  logic          advance_n,
    input  logic          wr_req_i,
    input  logic [AW-1:0] addr_i,
    output acc_e          acc_o,
    output logic [AW-1:0] eff_addr_o,
    output logic          rd_valid_o,
    output logic          mask_o
);
    localparam int BW = AW - 2;

    typedef struct packed {
        logic          active;
        logic [BW-1:0] base;
        logic [1:0]    cnt;
        logic          rd_valid;
        logic          mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.mask     = 1'b0;
        acc_o         = ACC_NONE;
        eff_addr_o    = {st_q.base, st_q.cnt};
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = addr_i[AW-1:2];
            st_d.cnt    = addr_i[1:0];
            eff_addr_o  = addr_i;
            acc_o       = (from_cpu_i || !wr_req_i) ? ACC_READ : ACC_WRITE;
        end else if (desel_i) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (!advance_n) begin
                st_d.cnt = st_q.cnt + 2'd1;
            end
            eff_addr_o = {st_q.base, st_d.cnt};
            acc_o      = wr_req_i ? ACC_WRITE : ACC_READ;
        end
        if (acc_o == ACC_READ) begin
            st_d.rd_valid = 1'b1;
            st_d.mask     = !st_q.active;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid_o = st_q.rd_valid;
    assign mask_o     = st_q.mask;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !start_i && !desel_i && !advance_n) |=> (st_q.cnt == $past(st_q.cnt) + 2'd1)); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !start_i && !desel_i && advance_n) |=> ($stable(st_q.cnt) && $stable(st_q.base))); // R5
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.cnt == $past(addr_i[1:0]))); // R4
    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        desel_i |=> (!st_q.active && !st_q.rd_valid)); // R11
    AST_CPU_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && from_cpu_i) |-> (acc_o != ACC_WRITE)); // R3
    AST_MASK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !st_q.active && acc_o == ACC_READ) |=> (rd_valid_o && mask_o)); // R10
endmodule

// File: rtl/bsf_store.sv
`timescale 1ns/1ps
module bsf_store #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    parameter int SAW    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        we_i,
    input  logic                    rd_en_i,
    input  logic [SAW-1:0]          addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << SAW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] rd_d, rd_q;

        always_ff @(posedge clk) begin
            if (we_i[g]) begin
                bank[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        always_comb begin
            rd_d = rd_en_i ? bank[addr_i] : rd_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else begin
                rd_q <= rd_d;
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/burst_sram_front.sv
`timescale 1ns/1ps
module burst_sram_front
    import bsf_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int LANES    = 2,
    parameter int LANE_W   = 9,
    parameter int STORE_AW = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    advance_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    inout  wire  [LANES*LANE_W-1:0] data_io
);
    localparam int DW = LANES * LANE_W;

    logic              start, desel, from_cpu;
    logic              wr_req;
    logic [LANES-1:0]  lane_mask, lane_we;
    acc_e              acc;
    logic [ADDR_W-1:0] eff_addr;
    logic              rd_valid, mask;
    logic [DW-1:0]     rdata;
    logic              drive_en;
    logic              unused_hi;

    bsf_strobe_decode u_strobe (
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .start_o      (start),
        .desel_o      (desel),
        .from_cpu_o   (from_cpu)
    );

    bsf_write_decode #(.LANES(LANES)) u_wdec (
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .wr_req_o     (wr_req),
        .lane_mask_o  (lane_mask)
    );

    bsf_burst_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .desel_i    (desel),
        .from_cpu_i (from_cpu),
        .advance_n  (advance_n),
        .wr_req_i   (wr_req),
        .addr_i     (addr_i),
        .acc_o      (acc),
        .eff_addr_o (eff_addr),
        .rd_valid_o (rd_valid),
        .mask_o     (mask)
    );

    assign lane_we   = (acc == ACC_WRITE) ? lane_mask : '0;
    assign unused_hi = ^eff_addr[ADDR_W-1:STORE_AW];

    bsf_store #(.LANES(LANES), .LANE_W(LANE_W), .SAW(STORE_AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (lane_we),
        .rd_en_i (acc == ACC_READ),
        .addr_i  (eff_addr[STORE_AW-1:0]),
        .wdata_i (data_io),
        .rdata_o (rdata)
    );

    assign drive_en = rd_valid && !mask && !out_en_n;
    assign data_io  = drive_en ? rdata : {DW{1'bz}};

    AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> $past(acc == ACC_READ)); // R8
    AST_WE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |-> (wr_req && (start || eff_addr[1:0] == u_ctrl.st_d.cnt))); // R7
    AST_CPU_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_n && !sel_a_n) |-> (lane_we == '0)); // R3
    AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_WRITE && !all_wr_n) |-> (&lane_we)); // R6
endmodule

// File: tb/burst_sram_front_bench.sv
`timescale 1ns/1ps
module burst_sram_front_bench;
    localparam logic [17:0] FLOAT = 18'h3FFFF;
    localparam logic [17:0] D0 = 18'h12345, D1 = 18'h0ABCD, D2 = 18'h2468A, D3 = 18'h13579;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] addr_i = '0;
    logic        strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1;
    logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic        advance_n = 1'b1, all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
    logic [1:0]  lane_sel_n = 2'b11;
    logic        out_en_n = 1'b1;
    logic [17:0] tb_dq = '0;
    logic        tb_drv = 1'b0;
    wire  [17:0] data_io;

    int checks = 0;
    int errors = 0;
    logic [17:0] model [64];

    always #2.5 clk = ~clk;

    assign data_io = tb_drv ? tb_dq : 18'bz;
    for (genvar i = 0; i < 18; i++) begin : g_pu
        pullup (data_io[i]);
    end

    burst_sram_front u_burst_sram_front (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .advance_n(advance_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
        .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .data_io(data_io)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [17:0] exp);
        checks++;
        if (data_io !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, data_io, exp);
        end
    endtask

    task automatic idle();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; advance_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 2'b11; tb_drv = 1'b0;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    endtask

    task automatic t_reset();
        out_en_n = 1'b0;
        step();
        check("R12 bus released after reset", FLOAT);
    endtask

    task automatic t_burst_write();
        logic [17:0] vals [4];
        vals[0] = D0; vals[1] = D1; vals[2] = D2; vals[3] = D3;
        out_en_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            idle();
            all_wr_n = 1'b0; tb_drv = 1'b1; tb_dq = vals[k];
            if (k == 0) begin strobe_ctl_n = 1'b0; addr_i = 18'h00010; end
            else advance_n = 1'b0;
            step();
            model[16 + k] = vals[k];
        end
        idle(); strobe_ctl_n = 1'b0; sel_b = 1'b0;
        step();
        idle();
    endtask

    task automatic t_read_wrap();
        out_en_n = 1'b0;
        strobe_ctl_n = 1'b0; addr_i = 18'h00012;
        step();
        check("R10 first read after deselect masked", FLOAT);
        idle(); advance_n = 1'b0;
        step(); check("R5 R8 R6 burst 2->3", model[19]);
        step(); check("R5 R6 wrap 3->0", model[16]);
        step(); check("R5 R6 0->1", model[17]);
        advance_n = 1'b1;
        step(); check("R5 hold with advance high", model[17]);
        idle(); strobe_ctl_n = 1'b0; addr_i = 18'h00012;
        step(); check("R4 R10 load low bits, no mask while selected", model[18]);
        idle();
    endtask

    task automatic t_oe_async();
        out_en_n = 1'b1; #1;
        check("R9 output enable high releases bus", FLOAT);
        out_en_n = 1'b0; #1;
        check("R9 output enable low restores data", model[18]);
    endtask

    task automatic t_byte_write();
        out_en_n = 1'b1;
        idle(); strobe_ctl_n = 1'b0; addr_i = 18'h00011;
        lane_wr_en_n = 1'b0; lane_sel_n = 2'b10; tb_drv = 1'b1; tb_dq = 18'h3C0F0;
        step(); model[17][8:0] = 9'h0F0;
        idle(); advance_n = 1'b0; lane_wr_en_n = 1'b0; lane_sel_n = 2'b11;
        tb_drv = 1'b1; tb_dq = 18'h00000;
        step();
        idle(); advance_n = 1'b0; lane_wr_en_n = 1'b0; lane_sel_n = 2'b01;
        tb_drv = 1'b1; tb_dq = 18'h2A955;
        step(); model[19][17:9] = 9'h154;
        idle(); out_en_n = 1'b0; #1;
        check("R8 bus released after write edge", FLOAT);
        strobe_ctl_n = 1'b0; addr_i = 18'h00011;
        step(); check("R7 lane 0 only written", model[17]);
        idle(); advance_n = 1'b0;
        step(); check("R7 no lane selected writes nothing", model[18]);
        step(); check("R7 lane 1 only written", model[19]);
        idle();
    endtask

    task automatic t_priority();
        out_en_n = 1'b1;
        idle(); strobe_cpu_n = 1'b0; strobe_ctl_n = 1'b0; addr_i = 18'h00010;
        all_wr_n = 1'b0; tb_drv = 1'b1; tb_dq = 18'h05A5A;
        step();
        idle(); out_en_n = 1'b0; #1;
        check("R3 both strobes low is a read", model[16]);
    endtask

    task automatic t_cpu_gate();
        idle(); strobe_cpu_n = 1'b0; sel_a_n = 1'b1; advance_n = 1'b0;
        step(); check("R2 processor strobe ignored, burst continues", model[17]);
        idle(); strobe_cpu_n = 1'b0; addr_i = 18'h00013;
        step(); check("R2 processor strobe opens read", model[19]);
        idle();
    endtask

    task automatic t_deselect();
        idle(); strobe_ctl_n = 1'b0; sel_c_n = 1'b1; addr_i = 18'h00012;
        step(); check("R11 strobe with inactive select releases bus", FLOAT);
        idle(); out_en_n = 1'b1; advance_n = 1'b0; all_wr_n = 1'b0;
        tb_drv = 1'b1; tb_dq = 18'h00F0F;
        step();
        idle(); out_en_n = 1'b0; advance_n = 1'b0;
        step(); check("R11 no read while deselected", FLOAT);
        idle(); strobe_ctl_n = 1'b0; sel_b = 1'b0; addr_i = 18'h00010;
        step(); check("R1 select B low does not open access", FLOAT);
        idle(); strobe_ctl_n = 1'b0; sel_a_n = 1'b1; addr_i = 18'h00010;
        step(); check("R1 select A high does not open access", FLOAT);
        idle(); strobe_ctl_n = 1'b0; addr_i = 18'h00013;
        step(); check("R10 masked after deselect", FLOAT);
        idle(); advance_n = 1'b0;
        step(); check("R11 no write while deselected", model[16]);
        step(); check("R11 neighbour unchanged", model[17]);
        idle();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_burst_write();
        t_read_wrap();
        t_oe_async();
        t_byte_write();
        t_priority();
        t_cpu_gate();
        t_deselect();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule